// File: doc/BRIEF.md
# Stolen Memory Access Guard

This block sits in front of a DRAM port and screens each request against two regions that are held back from ordinary use. One region stores graphics translation table entries. Only hardware translation traffic may touch it: table fetches and hardware updates of table entries. The other region lies at the very top of memory and belongs to a management controller. No agent other than that controller may reach it. Every request gets a registered verdict of grant or block, along with flags that say which region it hit. A blocked request also raises a one-cycle error pulse, and its address is latched so that it can be read later.

The management region is not programmed with a base. Its base is worked out as the top of memory minus the programmed size. The translation region takes an explicit base and size, and it is checked only while internal graphics is enabled. All bounds are counted in 1 MB units and are compared against the upper bits of the 36-bit request address. A granted management-controller access to its own region is flagged as bypassing the remap path.

Top module: `stolen_guard`

## Requirements
- R1: With addrMb = reqAddr[35:20], a request hits the management region when mgmtBase <= addrMb < cfgTopMem. Here mgmtBase = cfgTopMem - cfgMgmtSize, or 0 when cfgMgmtSize exceeds cfgTopMem. A size of 0 gives an empty region.
- R2: A request that hits the management region is granted only when reqAgent is the management agent (code 1). Processor (0), graphics (2) and I/O (3) requests that hit it are blocked.
- R3: While cfgGfxEn is 1, a request hits the translation region when cfgXlatBase <= addrMb < cfgXlatBase + cfgXlatSize. The sum is formed at 17 bits and does not wrap. A size of 0 gives an empty region.
- R4: A request that hits the translation region is granted only when reqKind is a table fetch (1) or a table-entry update (2). Direct accesses (0) and the reserved kind (3) are blocked, whatever the agent.
- R5: While cfgGfxEn is 0, rspHitXlat stays 0 and the translation region blocks nothing.
- R6: rspBypass is 1 exactly when a management-agent request that hits the management region is granted.
- R7: A request that hits neither region is granted.
- R8: A request presented with reqValid high at a clock edge produces rspValid high for the following cycle. In that cycle rspGrant and rspBlock are complements of each other. rspValid is 0 after a cycle with no request.
- R9: Each blocked request raises errPulse for exactly the cycle in which its response is valid, and loads its address into faultAddr. In every other cycle faultAddr holds its value.
- R10: A request that hits both regions must satisfy both rules to be granted.
- R11: During reset and directly after it, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | A request is present this cycle |
| reqAddr | input | 36 | Byte address of the request |
| reqAgent | input | 2 | Requester: 0 processor, 1 management, 2 graphics, 3 I/O |
| reqKind | input | 2 | 0 direct, 1 table fetch, 2 table-entry update, 3 reserved |
| cfgTopMem | input | 16 | Top of memory in MB |
| cfgMgmtSize | input | 16 | Management region size in MB |
| cfgXlatBase | input | 16 | Translation region base in MB |
| cfgXlatSize | input | 16 | Translation region size in MB |
| cfgGfxEn | input | 1 | Internal graphics enabled |
| rspValid | output | 1 | Verdict for the previous cycle's request |
| rspGrant | output | 1 | Request may proceed |
| rspBlock | output | 1 | Request is refused |
| rspHitMgmt | output | 1 | Request hit the management region |
| rspHitXlat | output | 1 | Request hit the translation region |
| rspBypass | output | 1 | Granted management access that skips remapping |
| errPulse | output | 1 | One-cycle pulse for a blocked request |
| faultAddr | output | 36 | Address of the most recent blocked request |

## Verification
The hardest cases to reach are the region edges. These include a management region whose size exceeds the top of memory, an empty region of size zero, and a translation region whose end passes the 16-bit MB range. Overlap of the two regions is also hard to reach. The bench steers into each of these through chosen configurations. For each one it sweeps the MB field of the address over the lowest and the highest sixteen values, under all sixteen agent and kind pairs, with requests issued back to back. This back-to-back stream also exercises error pulses on consecutive cycles and fault-address updates from one blocked request to the next.

// File: rtl/sg_pkg.sv
package sg_pkg;
  typedef enum logic [1:0] {
    AGENT_CPU  = 2'd0,
    AGENT_MGMT = 2'd1,
    AGENT_GFX  = 2'd2,
    AGENT_IO   = 2'd3
  } agent_e;

  typedef enum logic [1:0] {
    KIND_DIRECT = 2'd0,
    KIND_FETCH  = 2'd1,
    KIND_UPDATE = 2'd2,
    KIND_RSVD   = 2'd3
  } kind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadRsp;
    logic loadFault;
  } strobes_t;
endpackage

// File: rtl/sg_datapath.sv
module sg_datapath
  import sg_pkg::*;
#(
  parameter int ADDR_W   = 36,
  parameter int MB_SHIFT = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqAgent,
  input  logic [1:0]        reqKind,
  input  logic [ADDR_W-MB_SHIFT-1:0] cfgTopMem,
  input  logic [ADDR_W-MB_SHIFT-1:0] cfgMgmtSize,
  input  logic [ADDR_W-MB_SHIFT-1:0] cfgXlatBase,
  input  logic [ADDR_W-MB_SHIFT-1:0] cfgXlatSize,
  input  logic              cfgGfxEn,
  input  strobes_t          strobes,
  output logic              blockNext,
  output logic              rspGrant,
  output logic              rspBlock,
  output logic              rspHitMgmt,
  output logic              rspHitXlat,
  output logic              rspBypass,
  output logic [ADDR_W-1:0] faultAddr
);
  localparam int MB_W = ADDR_W - MB_SHIFT;

  logic [MB_W-1:0] addrMb;
  logic [MB_W-1:0] mgmtBase;
  logic [MB_W:0]   xlatEnd;
  logic            hitMgmt, hitXlat, mgmtDeny, xlatDeny, bypassNext;
  agent_e          agent;
  kind_e           kind;

  always_comb begin
    agent    = agent_e'(reqAgent);
    kind     = kind_e'(reqKind);
    addrMb   = reqAddr[ADDR_W-1:MB_SHIFT];
    // base derived from top of memory, clamped at zero
    mgmtBase = (cfgMgmtSize > cfgTopMem) ? '0 : cfgTopMem - cfgMgmtSize;
    hitMgmt  = (addrMb >= mgmtBase) && (addrMb < cfgTopMem);
    xlatEnd  = {1'b0, cfgXlatBase} + {1'b0, cfgXlatSize};
    hitXlat  = cfgGfxEn && (addrMb >= cfgXlatBase) && ({1'b0, addrMb} < xlatEnd);
    mgmtDeny = hitMgmt && (agent != AGENT_MGMT);
    xlatDeny = hitXlat && !((kind == KIND_FETCH) || (kind == KIND_UPDATE));
    blockNext  = mgmtDeny || xlatDeny;
    bypassNext = hitMgmt && !blockNext;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspGrant   <= 1'b0;
      rspBlock   <= 1'b0;
      rspHitMgmt <= 1'b0;
      rspHitXlat <= 1'b0;
      rspBypass  <= 1'b0;
    end else if (strobes.loadRsp) begin
      rspGrant   <= !blockNext;
      rspBlock   <= blockNext;
      rspHitMgmt <= hitMgmt;
      rspHitXlat <= hitXlat;
      rspBypass  <= bypassNext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                  faultAddr <= '0;
    else if (strobes.loadFault) faultAddr <= reqAddr;
  end

  // R2: a granted hit on the management region came from the management agent
  p_mgmt_owner_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadRsp |=> (!(rspGrant && rspHitMgmt) || $past(reqAgent) == AGENT_MGMT));

  // R4: a granted hit on the translation region was a hardware kind
  p_xlat_kind_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadRsp |=> (!(rspGrant && rspHitXlat) ||
      $past(reqKind) == KIND_FETCH || $past(reqKind) == KIND_UPDATE));

  // R5: graphics disabled means no translation hit
  p_gfx_off_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.loadRsp && !cfgGfxEn) |=> !rspHitXlat);

  // R6: bypass only on granted management hits
  p_bypass_r6: assert property (@(posedge clk) disable iff (!rstN)
    rspBypass |-> (rspHitMgmt && rspGrant));

  // R9: fault address moves only on a capture
  p_fault_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.loadFault |=> $stable(faultAddr));
endmodule

// File: rtl/sg_ctrl.sv
module sg_ctrl
  import sg_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     reqValid,
  input  logic     blockNext,
  output strobes_t strobes,
  output logic     rspValid,
  output logic     errPulse
);
  always_comb begin
    strobes.loadRsp   = reqValid;
    strobes.loadFault = reqValid && blockNext;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      errPulse <= 1'b0;
    end else begin
      rspValid <= reqValid;
      errPulse <= reqValid && blockNext;
    end
  end

  // R8: a response follows each request, and only a request
  p_rsp_follows_r8: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);
  p_rsp_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid);
endmodule

// File: rtl/stolen_guard.sv
module stolen_guard
  import sg_pkg::*;
#(
  parameter int ADDR_W   = 36,
  parameter int MB_SHIFT = 20,
  localparam int MB_W    = ADDR_W - MB_SHIFT
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqAgent,
  input  logic [1:0]        reqKind,
  input  logic [MB_W-1:0]   cfgTopMem,
  input  logic [MB_W-1:0]   cfgMgmtSize,
  input  logic [MB_W-1:0]   cfgXlatBase,
  input  logic [MB_W-1:0]   cfgXlatSize,
  input  logic              cfgGfxEn,
  output logic              rspValid,
  output logic              rspGrant,
  output logic              rspBlock,
  output logic              rspHitMgmt,
  output logic              rspHitXlat,
  output logic              rspBypass,
  output logic              errPulse,
  output logic [ADDR_W-1:0] faultAddr
);
  strobes_t strobes;
  logic     blockNext;

  sg_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .blockNext(blockNext),
    .strobes(strobes), .rspValid(rspValid), .errPulse(errPulse)
  );

  sg_datapath #(.ADDR_W(ADDR_W), .MB_SHIFT(MB_SHIFT)) u_dp (
    .clk(clk), .rstN(rstN), .reqAddr(reqAddr), .reqAgent(reqAgent),
    .reqKind(reqKind), .cfgTopMem(cfgTopMem), .cfgMgmtSize(cfgMgmtSize),
    .cfgXlatBase(cfgXlatBase), .cfgXlatSize(cfgXlatSize), .cfgGfxEn(cfgGfxEn),
    .strobes(strobes), .blockNext(blockNext), .rspGrant(rspGrant),
    .rspBlock(rspBlock), .rspHitMgmt(rspHitMgmt), .rspHitXlat(rspHitXlat),
    .rspBypass(rspBypass), .faultAddr(faultAddr)
  );

  // R8: exactly one verdict per valid response
  p_verdict_r8: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> (rspGrant != rspBlock));

  // R9: error pulse marks a valid blocked response and carries its address
  p_err_blocked_r9: assert property (@(posedge clk) disable iff (!rstN)
    errPulse |-> (rspValid && rspBlock));
  p_err_addr_r9: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && blockNext |=> (errPulse && faultAddr == $past(reqAddr)));
endmodule

// File: tb/tb_stolen_guard.sv
`timescale 1ns/1ps
module tb_stolen_guard;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [35:0] reqAddr = '0;
  logic [1:0]  reqAgent = '0;
  logic [1:0]  reqKind = '0;
  logic [15:0] cfgTopMem = '0, cfgMgmtSize = '0, cfgXlatBase = '0, cfgXlatSize = '0;
  logic        cfgGfxEn = 1'b0;
  logic        rspValid, rspGrant, rspBlock, rspHitMgmt, rspHitXlat, rspBypass, errPulse;
  logic [35:0] faultAddr;

  int nChk = 0;
  int nBad = 0;
  logic [35:0] expFault = '0;

  always #2 clk = ~clk;

  stolen_guard dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqAgent(reqAgent), .reqKind(reqKind), .cfgTopMem(cfgTopMem),
    .cfgMgmtSize(cfgMgmtSize), .cfgXlatBase(cfgXlatBase), .cfgXlatSize(cfgXlatSize),
    .cfgGfxEn(cfgGfxEn), .rspValid(rspValid), .rspGrant(rspGrant),
    .rspBlock(rspBlock), .rspHitMgmt(rspHitMgmt), .rspHitXlat(rspHitXlat),
    .rspBypass(rspBypass), .errPulse(errPulse), .faultAddr(faultAddr)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic setCfg(input logic [15:0] top, ms, xb, xs, input logic gfx);
    cfgTopMem = top; cfgMgmtSize = ms; cfgXlatBase = xb; cfgXlatSize = xs; cfgGfxEn = gfx;
  endtask

  task automatic sweep();
    for (int idx = 0; idx < 32; idx++) begin
      for (int ak = 0; ak < 16; ak++) begin
        logic [15:0] mb;
        logic [15:0] mBase;
        logic [16:0] xEnd;
        logic hm, hx, mDeny, xDeny, blk;
        string tag;
        mb = (idx < 16) ? 16'(idx) : 16'(16'hFFF0 + idx - 16);
        reqValid = 1'b1;
        reqAgent = 2'(ak >> 2);
        reqKind  = 2'(ak & 3);
        reqAddr  = {mb, 20'(idx * 4099 + ak * 17 + 5)};
        mBase = (cfgMgmtSize > cfgTopMem) ? 16'd0 : cfgTopMem - cfgMgmtSize;
        hm = (mb >= mBase) && (mb < cfgTopMem);
        xEnd = 17'(cfgXlatBase) + 17'(cfgXlatSize);
        hx = cfgGfxEn && (mb >= cfgXlatBase) && (17'(mb) < xEnd);
        mDeny = hm && (reqAgent != 2'd1);
        xDeny = hx && !(reqKind == 2'd1 || reqKind == 2'd2);
        blk = mDeny || xDeny;
        if (hm && hx) tag = "R10 both regions";
        else if (hm) tag = "R2 management region";
        else if (hx) tag = "R4 translation region";
        else if (!cfgGfxEn) tag = "R5 graphics off";
        else tag = "R7 outside regions";
        if (blk) expFault = reqAddr;
        @(posedge clk);
        @(negedge clk);
        chk("R8 rspValid", 64'(rspValid), 64'd1);
        chk({tag, " grant"}, 64'(rspGrant), 64'(!blk));
        chk({tag, " block"}, 64'(rspBlock), 64'(blk));
        chk("R1 management hit", 64'(rspHitMgmt), 64'(hm));
        chk(cfgGfxEn ? "R3 translation hit" : "R5 translation hit", 64'(rspHitXlat), 64'(hx));
        chk("R6 bypass", 64'(rspBypass), 64'(hm && !blk));
        chk("R9 errPulse", 64'(errPulse), 64'(blk));
        chk("R9 faultAddr", 64'(faultAddr), 64'(expFault));
      end
    end
    reqValid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R8 idle rspValid", 64'(rspValid), 64'd0);
    chk("R9 idle errPulse", 64'(errPulse), 64'd0);
    chk("R9 idle faultAddr", 64'(faultAddr), 64'(expFault));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChk++; nBad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    setCfg(16'd12, 16'd3, 16'd4, 16'd3, 1'b1);
    reqValid = 1'b1;
    reqAddr  = {16'd10, 20'h1};
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R11 reset rspValid", 64'(rspValid), 64'd0);
    chk("R11 reset grant", 64'(rspGrant), 64'd0);
    chk("R11 reset block", 64'(rspBlock), 64'd0);
    chk("R11 reset errPulse", 64'(errPulse), 64'd0);
    chk("R11 reset faultAddr", 64'(faultAddr), 64'd0);
    reqValid = 1'b0;
    rstN = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R11 after reset rspValid", 64'(rspValid), 64'd0);
    chk("R11 after reset bypass", 64'(rspBypass), 64'd0);

    setCfg(16'd12, 16'd3, 16'd4, 16'd3, 1'b1);            sweep();  // separate regions
    setCfg(16'd10, 16'd4, 16'd5, 16'd3, 1'b1);            sweep();  // R10 overlap
    setCfg(16'd12, 16'd3, 16'd4, 16'd3, 1'b0);            sweep();  // R5 graphics off
    setCfg(16'd12, 16'd0, 16'd2, 16'd2, 1'b1);            sweep();  // R1 empty management
    setCfg(16'd5, 16'd8, 16'd8, 16'd0, 1'b1);             sweep();  // R1 clamp, R3 empty
    setCfg(16'hFFFF, 16'd2, 16'hFFFC, 16'd8, 1'b1);       sweep();  // R3 end past 16 bits

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule